// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block gathers thirty-two level-sensitive maskable request lines and one edge-triggered non-maskable input. It presents a single interrupt-request signal and a dispatch-table index to a processor core. Each maskable line passes through its own bit in one of two 16-bit enable registers. All maskable lines are then gated by one global enable bit. Among the survivors, the line with the highest number wins, and the index reported is 16 plus that number.

A latched non-maskable event outranks every maskable request and reports index 1. The enable registers and the global bit have no effect on it. The global bit can be written over the bus. It can also be set or cleared in one cycle by dedicated command pulses, so software never needs a read-modify-write sequence on it. The non-maskable input has three views: a control/status register that holds its enable and its pending flag, a status register that reads the latched event and clears it on read, and a monitor register that shows the live pin level.

The core reads the vector register, or pulses the acknowledge input. An acknowledge given while the non-maskable event is pending retires that event. Maskable sources keep their request high until they are serviced.

Top module: `icu_top`

## Requirements
- R1: Of the requests that are pending, enabled by their mask bit and gated by a global enable of 1, the one with the highest line number n wins. The vector register (address 3, bits 6:0) then reads 16+n and `int_out` is 1.
- R2: Mask register address 1 bit i enables line i. Mask register address 2 bit i enables line 16+i. A line whose mask bit is 0 never wins.
- R3: While the global enable (address 0 bit 0) is 0 and no non-maskable event is pending, `int_out` is 0 and the vector reads 0, whatever `irq_req` and the masks hold.
- R4: A `gie_clr` pulse makes the global enable 0 in the next cycle. Otherwise a `gie_set` pulse makes it 1. Either command overrides a bus write to address 0 in the same cycle. With neither command, a bus write loads `bus_wdata[0]`.
- R5: A rising edge on `nmi_in` while the non-maskable enable (address 6 bit 0) is 1 latches a pending flag. While the flag is set, `int_out` is 1 and the vector reads 1, regardless of masks and global enable. An edge while the enable is 0 latches nothing.
- R6: The pending flag is readable at address 4 bit 0 and at address 6 bit 1. A read of address 4 clears it. An `int_ack` while it is set also clears it. A new enabled edge in the same cycle keeps it set.
- R7: Address 5 bit 0 reads the live level of `nmi_in`.
- R8: With nothing pending, the vector reads 0 and `int_out` is 0.
- R9: After reset, both mask registers, the global enable, the non-maskable enable and the pending flag are 0. Reads while the bus is idle, or of addresses 7 and above, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| irq_req | input | 32 | Maskable request levels, bit n = line n |
| nmi_in | input | 1 | Non-maskable input, edge-detected |
| gie_set | input | 1 | Set global enable command |
| gie_clr | input | 1 | Clear global enable command |
| int_ack | input | 1 | Acknowledge from the core |
| int_out | output | 1 | Interrupt request to the core |

## Verification
The winner logic is tried with a single line walked across all thirty-two positions, which exposes a wrong index offset or a wrong bank mapping. It is also tried with paired lines that straddle the bank boundary and the extremes, which shows whether the higher number is picked. Mask patterns that hide the highest pending line show that the mask gates each line, not just the winner. Command pulses that collide with each other and with bus writes pin down the override order. The non-maskable path is tried with edges under a disabled and an enabled control, and with clears that coincide with a new edge, which separates edge latching from level following and shows which source wins a collision. A long random phase mixes all of these against the cycle model.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_GIE   = 3'd0,
    A_MLO   = 3'd1,
    A_MHI   = 3'd2,
    A_VEC   = 3'd3,
    A_NSTAT = 3'd4,
    A_NMON  = 3'd5,
    A_NCTL  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/icu_mask_bank.sv
module icu_mask_bank #(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_IRQ-1:0] mask_o
);
  import icu_pkg::*;
  localparam int NUM_BANKS = NUM_IRQ / DATA_W;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              bank_we;
    logic [DATA_W-1:0] bank_d, bank_q;

    always_comb begin
      bank_we = wr_en && (wr_addr == ADDR_W'(int'(A_MLO) + b));
      bank_d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q <= '0;
      else if (bank_we) bank_q <= bank_d;
    end

    assign mask_o[b*DATA_W +: DATA_W] = bank_q;
  end
endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     act,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/icu_nmi_unit.sv
module icu_nmi_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic en_we,
  input  logic en_d,
  input  logic rd_clr,
  input  logic ack,
  output logic en_o,
  output logic pend_o,
  output logic rise_o
);
  logic lvl_q, en_q, pend_q, pend_d;

  assign rise_o = nmi_in && !lvl_q;

  always_comb begin
    pend_d = pend_q;
    if (en_q && rise_o)              pend_d = 1'b1;
    else if (rd_clr || (ack && pend_q)) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= nmi_in;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/icu_top.sv
module icu_top #(
  parameter int NUM_IRQ  = 32,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int VEC_BASE = 16,
  parameter int NMI_VEC  = 1,
  parameter int VEC_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               nmi_in,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               int_ack,
  output logic               int_out
);
  import icu_pkg::*;
  localparam int IDX_W     = $clog2(NUM_IRQ);
  localparam int NUM_BANKS = NUM_IRQ / DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic wr_en, rd_en;
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  // global enable
  logic gie_q, gie_d, gie_we;
  always_comb begin
    gie_we = gie_clr || gie_set || (wr_en && bus_addr == A_GIE);
    if (gie_clr)      gie_d = 1'b0;
    else if (gie_set) gie_d = 1'b1;
    else              gie_d = bus_wdata[0];
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  gie_q <= 1'b0;
    else if (gie_we)  gie_q <= gie_d;
  end

  logic [NUM_IRQ-1:0] mask;
  icu_mask_bank #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(bus_addr),
    .wdata(bus_wdata), .mask_o(mask)
  );

  logic nmi_en, nmi_pend, nmi_rise;
  icu_nmi_unit u_nmi (
    .clk(clk), .rst_n(rst_sync_n), .nmi_in(nmi_in),
    .en_we(wr_en && bus_addr == A_NCTL), .en_d(bus_wdata[0]),
    .rd_clr(rd_en && bus_addr == A_NSTAT), .ack(int_ack),
    .en_o(nmi_en), .pend_o(nmi_pend), .rise_o(nmi_rise)
  );

  logic [NUM_IRQ-1:0] active;
  logic               hit;
  logic [IDX_W-1:0]   win_idx;
  assign active = irq_req & mask & {NUM_IRQ{gie_q}};

  icu_prio_enc #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_prio (
    .act(active), .hit(hit), .idx(win_idx)
  );

  logic [VEC_W-1:0] vector;
  always_comb begin
    if (nmi_pend) vector = VEC_W'(NMI_VEC);
    else if (hit) vector = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    else          vector = '0;
  end

  assign int_out = nmi_pend || hit;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        A_GIE:   bus_rdata = DATA_W'(gie_q);
        A_VEC:   bus_rdata = DATA_W'(vector);
        A_NSTAT: bus_rdata = DATA_W'(nmi_pend);
        A_NMON:  bus_rdata = DATA_W'(nmi_in);
        A_NCTL:  bus_rdata = DATA_W'({nmi_pend, nmi_en});
        default: bus_rdata = '0;
      endcase
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr == ADDR_W'(int'(A_MLO) + b))
          bus_rdata = mask[b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
  parameter int VEC_BASE = 16,
  parameter int NMI_VEC  = 1,
  parameter int VEC_W    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie_set,
  input logic             gie_clr,
  input logic             int_ack,
  input logic             int_out,
  input logic             gie_q,
  input logic             nmi_pend,
  input logic             nmi_rise,
  input logic [VEC_W-1:0] vector
);
  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie_q);
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set && !gie_clr) |=> gie_q);
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && nmi_pend && !nmi_rise) |=> !nmi_pend);
  p_nmi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (int_out && vector == VEC_W'(NMI_VEC)));
  p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !nmi_pend) |-> !int_out);
  p_vec_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && !nmi_pend) |-> vector >= VEC_W'(VEC_BASE));
  p_idle_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !int_out |-> vector == '0);
endmodule

bind icu_top icu_chk #(.VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .gie_set(gie_set), .gie_clr(gie_clr),
  .int_ack(int_ack), .int_out(int_out), .gie_q(gie_q), .nmi_pend(nmi_pend),
  .nmi_rise(nmi_rise), .vector(vector)
);

// File: tb/icu_top_tb_top.sv
`timescale 1ns/1ps
module icu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [31:0] irq_req;
  logic        nmi_in, gie_set, gie_clr, int_ack, int_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  icu_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .nmi_in(nmi_in), .gie_set(gie_set), .gie_clr(gie_clr),
    .int_ack(int_ack), .int_out(int_out)
  );

  // behavioural reference
  bit          m_gie, m_nen, m_pend, m_prev;
  logic [15:0] m_mlo, m_mhi;

  function automatic int exp_vec();
    logic [31:0] en;
    if (m_pend) return 1;
    if (!m_gie) return 0;
    en = {m_mhi, m_mlo};
    for (int n = 31; n >= 0; n--)
      if (irq_req[n] && en[n]) return 16 + n;
    return 0;
  endfunction

  function automatic logic [15:0] exp_rd();
    if (!(bus_sel && !bus_wr)) return 16'h0;
    case (bus_addr)
      3'd0: return {15'h0, m_gie};
      3'd1: return m_mlo;
      3'd2: return m_mhi;
      3'd3: return 16'(exp_vec());
      3'd4: return {15'h0, m_pend};
      3'd5: return {15'h0, nmi_in};
      3'd6: return {14'h0, m_pend, m_nen};
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gie = 0; m_nen = 0; m_pend = 0; m_prev = 0; m_mlo = '0; m_mhi = '0;
    end else begin
      bit rise, wr, rd;
      rise = nmi_in && !m_prev;
      wr = bus_sel && bus_wr;
      rd = bus_sel && !bus_wr;
      if (m_nen && rise) m_pend = 1;
      else if ((rd && bus_addr == 3'd4) || (int_ack && m_pend)) m_pend = 0;
      m_prev = nmi_in;
      if (wr && bus_addr == 3'd6) m_nen = bus_wdata[0];
      if (gie_clr) m_gie = 0;
      else if (gie_set) m_gie = 1;
      else if (wr && bus_addr == 3'd0) m_gie = bus_wdata[0];
      if (wr && bus_addr == 3'd1) m_mlo = bus_wdata;
      if (wr && bus_addr == 3'd2) m_mhi = bus_wdata;
    end
  end

  task automatic compare(string tag);
    bit          e_int;
    logic [15:0] e_rd;
    #1;
    e_int = (exp_vec() != 0);
    checks++;
    if (int_out !== e_int) begin
      fails++;
      $display("FAIL %s int_out actual %0d expected %0d", tag, int_out, e_int);
    end
    e_rd = exp_rd();
    checks++;
    if (bus_rdata !== e_rd) begin
      fails++;
      $display("FAIL %s rdata addr %0d actual %h expected %h", tag, bus_addr, bus_rdata, e_rd);
    end
  endtask

  task automatic tick(string tag);
    compare(tag);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; gie_set = 0; gie_clr = 0; int_ack = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, string tag);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick(tag);
  endtask

  task automatic rd(input logic [2:0] a, string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    irq_req = 0; nmi_in = 0; gie_set = 0; gie_clr = 0; int_ack = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R9: reset state of every register
    for (int a = 0; a < 8; a++) rd(3'(a), "R9");
    irq_req = 32'hFFFF_FFFF;
    tick("R9");

    // R3: global enable off hides everything
    wr(3'd1, 16'hFFFF, "R3");
    wr(3'd2, 16'hFFFF, "R3");
    rd(3'd3, "R3");
    wr(3'd0, 16'h0001, "R3");
    rd(3'd3, "R3");

    // R1: walking single line, then pairs
    for (int n = 0; n < 32; n++) begin
      irq_req = 32'h1 << n;
      rd(3'd3, "R1");
    end
    irq_req = 32'h8000_0001; rd(3'd3, "R1");
    irq_req = 32'h0001_8000; rd(3'd3, "R1");
    irq_req = 32'h0000_0003; rd(3'd3, "R1");

    // R2: masks hide the highest pending line
    irq_req = 32'hFFFF_FFFF;
    wr(3'd2, 16'h7FFF, "R2"); rd(3'd3, "R2");
    wr(3'd2, 16'h0000, "R2"); rd(3'd3, "R2");
    wr(3'd1, 16'h0100, "R2"); rd(3'd3, "R2");
    wr(3'd1, 16'h0000, "R2"); rd(3'd3, "R2");
    rd(3'd1, "R2"); rd(3'd2, "R2");
    wr(3'd1, 16'hFFFF, "R2"); wr(3'd2, 16'hFFFF, "R2");

    // R4: command pulses and collisions
    gie_clr = 1; tick("R4"); rd(3'd0, "R4");
    gie_set = 1; tick("R4"); rd(3'd0, "R4");
    gie_set = 1; gie_clr = 1; tick("R4"); rd(3'd0, "R4");
    gie_set = 1; wr(3'd0, 16'h0000, "R4"); rd(3'd0, "R4");
    gie_clr = 1; wr(3'd0, 16'h0001, "R4"); rd(3'd0, "R4");
    wr(3'd0, 16'h0001, "R4"); rd(3'd0, "R4");

    // R8: nothing pending
    irq_req = 0; rd(3'd3, "R8");

    // R5: disabled edge latches nothing, enabled edge latches
    nmi_in = 1; rd(3'd4, "R5"); nmi_in = 0; rd(3'd4, "R5");
    wr(3'd6, 16'h0001, "R5");
    irq_req = 32'h8000_0000; gie_clr = 1; tick("R5");
    nmi_in = 1; tick("R5"); rd(3'd3, "R5"); rd(3'd6, "R5");

    // R7: monitor follows level
    rd(3'd5, "R7"); nmi_in = 0; rd(3'd5, "R7");

    // R6: clear by read, by acknowledge, and collision with new edge
    rd(3'd4, "R6"); rd(3'd4, "R6");
    nmi_in = 1; tick("R6"); nmi_in = 0; tick("R6");
    int_ack = 1; tick("R6"); rd(3'd6, "R6");
    nmi_in = 1; tick("R6"); nmi_in = 0; tick("R6");
    nmi_in = 1; bus_sel = 1; bus_wr = 0; bus_addr = 3'd4; tick("R6");
    rd(3'd4, "R6");
    nmi_in = 0; int_ack = 1; tick("R6");

    // R1: random mix against the model
    for (int i = 0; i < 600; i++) begin
      irq_req = $urandom;
      if ($urandom_range(0, 3) == 0) nmi_in = ~nmi_in;
      gie_set = ($urandom_range(0, 7) == 0);
      gie_clr = ($urandom_range(0, 7) == 0);
      int_ack = ($urandom_range(0, 5) == 0);
      bus_sel = $urandom_range(0, 1);
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_addr = 3'($urandom);
      bus_wdata = 16'($urandom);
      tick("R1");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule